// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a small arithmetic peripheral that sits on a simple word-addressed register bus. Software loads a first operand and then a second operand. The write of the second operand makes the block compute a product in the same clock edge. Depending on the address that received the first operand, the product either replaces the 32-bit result or is added to it.

The first operand register shows up at four bus addresses. The address that is written selects one of four operations and holds that choice until the next first-operand write:
- unsigned multiply
- signed multiply
- unsigned multiply-accumulate
- signed multiply-accumulate

Operands can be written as a full word or as a single byte. A byte is widened according to the signedness of the selected operation, so 16x16, 16x8, 8x16 and 8x8 products all come from the same datapath. The result is held as a low word, a high word and an extension word. All three can be read on the very next bus access.

The result words can also be written, which sets the starting value of an accumulation.

Top module: `mac_periph`

## Requirements
- R1: Word index bits [1:0] of an operand-1 write pick the operation: index 0 unsigned multiply, 1 signed multiply, 2 unsigned accumulate, 3 signed accumulate. Bit 0 means signed and bit 1 means accumulate. Operand 2 is at index 4, the result low word at 5, the result high word at 6 and the extension word at 7.
- R2: In unsigned multiply, the 32-bit result becomes the unsigned product of the operands and the extension word becomes 0x0000.
- R3: In signed multiply, the result becomes the two's-complement product. The extension word is 0xFFFF when the product is negative and 0x0000 otherwise.
- R4: In unsigned accumulate, the product is added to the previous 32-bit result. The result keeps the low 32 bits of the sum and the extension word holds the carry out of bit 31 (0x0001 or 0x0000).
- R5: In signed accumulate, the product is added to the previous result, wrapping at 32 bits. The extension word is 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R6: With byte_wr high, an operand write takes only wdata[7:0] and ignores wdata[15:8]. The byte is zero-extended for unsigned operations and sign-extended for signed ones. An operand-2 byte uses the operation chosen by the last operand-1 write.
- R7: A read at any of the four operand-1 indices returns the stored, widened operand 1. A read at index 4 returns the widened operand 2.
- R8: Every write to operand 2 starts an operation. Writing operand 2 again, without touching operand 1, repeats the operation with the held operand 1 and mode.
- R9: rdata is registered and shows the addressed register one cycle after the address is presented. A read issued in the cycle right after an operand-2 write returns the new result, with no further wait.
- R10: Word writes to indices 5 and 6 preset the result. Accumulate operations add to this value, and the two multiply operations ignore it.
- R11: Reset clears both operands, the result, the extension word and rdata to zero, and selects unsigned multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| byte_wr | input | 1 | Operand write carries a single byte in wdata[7:0] |
| addr | input | ADDR_W | Word index of the register accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the addressed register |

## Verification
The hardest behaviour to reach is the pair of corner results in the accumulate modes: a carry out of the 32-bit unsigned sum, and a signed sum that crosses from the largest positive value into the negative range. Both depend on the accumulator state, which can only be reached through several operations. The stimulus writes the result words directly with values next to those limits before it triggers a single accumulate. Byte writes carry nonzero upper bits, so any leak of those bits into the product would change the result.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // bit 0 of the mode selects signed arithmetic, bit 1 selects accumulation
  typedef enum logic [1:0] {
    MD_UMUL = 2'd0,
    MD_SMUL = 2'd1,
    MD_UMAC = 2'd2,
    MD_SMAC = 2'd3
  } mac_mode_e;

  localparam int unsigned IDX_OP1_LAST = 3;
  localparam int unsigned IDX_OP2      = 4;
  localparam int unsigned IDX_RES_LO   = 5;
  localparam int unsigned IDX_RES_HI   = 6;
  localparam int unsigned IDX_EXT      = 7;

  function automatic logic mode_is_signed(input mac_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/mac_operands.sv
module mac_operands
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op1_we,
  input  logic              op2_we,
  input  logic              byte_wr,
  input  mac_mode_e         mode_in,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] op1_q,
  output logic [DATA_W-1:0] op2_q,
  output logic [DATA_W-1:0] op2_val,
  output mac_mode_e         mode_q
);

  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam int unsigned HIGH_W = DATA_W - BYTE_W;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] d,
                                              input logic is_byte,
                                              input logic sgn);
    logic [DATA_W-1:0] r;
    if (is_byte) r = {{HIGH_W{sgn & d[BYTE_W-1]}}, d[BYTE_W-1:0]};
    else         r = d;
    return r;
  endfunction

  logic [DATA_W-1:0] op1_val;

  // operand 1 is widened by the mode carried in its own address
  always_comb op1_val = widen(wdata, byte_wr, mode_is_signed(mode_in));
  // operand 2 is widened by the mode already held
  always_comb op2_val = widen(wdata, byte_wr, mode_is_signed(mode_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= MD_UMUL;
    end else begin
      if (op1_we) begin
        op1_q  <= op1_val;
        mode_q <= mode_in;
      end
      if (op2_we) op2_q <= op2_val;
    end
  end

endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]   op1,
  input  logic [DATA_W-1:0]   op2,
  input  mac_mode_e           mode,
  input  logic [2*DATA_W-1:0] acc,
  output logic [2*DATA_W-1:0] next_res,
  output logic [DATA_W-1:0]   next_ext
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod_u;
  logic [PROD_W-1:0] prod_s;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   sum;

  always_comb begin
    prod_u = {{DATA_W{1'b0}}, op1} * {{DATA_W{1'b0}}, op2};
    prod_s = $unsigned($signed({{DATA_W{op1[DATA_W-1]}}, op1}) *
                       $signed({{DATA_W{op2[DATA_W-1]}}, op2}));
    prod   = mode_is_signed(mode) ? prod_s : prod_u;
    sum    = {1'b0, acc} + {1'b0, prod};
  end

  always_comb begin
    unique case (mode)
      MD_UMUL: begin
        next_res = prod;
        next_ext = '0;
      end
      MD_SMUL: begin
        next_res = prod;
        next_ext = {DATA_W{prod[PROD_W-1]}};
      end
      MD_UMAC: begin
        next_res = sum[PROD_W-1:0];
        next_ext = {{(DATA_W-1){1'b0}}, sum[PROD_W]};
      end
      default: begin
        next_res = sum[PROD_W-1:0];
        next_ext = {DATA_W{sum[PROD_W-1]}};
      end
    endcase
  end

endmodule

// File: rtl/mac_result.sv
module mac_result #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] next_res,
  input  logic [DATA_W-1:0]   next_ext,
  output logic [2*DATA_W-1:0] res_q,
  output logic [DATA_W-1:0]   ext_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ext_q <= '0;
    end else if (go) begin
      res_q <= next_res;
      ext_q <= next_ext;
    end else begin
      if (lo_we) res_q[DATA_W-1:0]        <= wdata;
      if (hi_we) res_q[2*DATA_W-1:DATA_W] <= wdata;
    end
  end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              byte_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic              is_op1, is_op2, is_lo, is_hi, is_ext;
  logic [DATA_W-1:0] op1_q, op2_q, op2_val, ext_q, next_ext;
  logic [PROD_W-1:0] res_q, next_res;
  mac_mode_e         mode_q;
  mac_mode_e         mode_in;

  always_comb begin
    is_op1  = addr <= ADDR_W'(IDX_OP1_LAST);
    is_op2  = addr == ADDR_W'(IDX_OP2);
    is_lo   = addr == ADDR_W'(IDX_RES_LO);
    is_hi   = addr == ADDR_W'(IDX_RES_HI);
    is_ext  = addr == ADDR_W'(IDX_EXT);
    mode_in = mac_mode_e'(addr[1:0]);
  end

  mac_operands #(.DATA_W(DATA_W)) u_ops (
    .clk     (clk),
    .rst     (rst),
    .op1_we  (wr_en & is_op1),
    .op2_we  (wr_en & is_op2),
    .byte_wr (byte_wr),
    .mode_in (mode_in),
    .wdata   (wdata),
    .op1_q   (op1_q),
    .op2_q   (op2_q),
    .op2_val (op2_val),
    .mode_q  (mode_q)
  );

  mac_arith #(.DATA_W(DATA_W)) u_arith (
    .op1      (op1_q),
    .op2      (op2_val),
    .mode     (mode_q),
    .acc      (res_q),
    .next_res (next_res),
    .next_ext (next_ext)
  );

  mac_result #(.DATA_W(DATA_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .go       (wr_en & is_op2),
    .lo_we    (wr_en & is_lo),
    .hi_we    (wr_en & is_hi),
    .wdata    (wdata),
    .next_res (next_res),
    .next_ext (next_ext),
    .res_q    (res_q),
    .ext_q    (ext_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (is_op1) rdata <= op1_q;
      if (is_op2) rdata <= op2_q;
      if (is_lo)  rdata <= res_q[DATA_W-1:0];
      if (is_hi)  rdata <= res_q[PROD_W-1:DATA_W];
      if (is_ext) rdata <= ext_q;
    end
  end

endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                byte_wr,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [2*DATA_W-1:0] res_q,
  input logic [DATA_W-1:0]   ext_q
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [1:0] seen_mode;
  logic       op2_wr, res_touch;

  always_ff @(posedge clk) begin
    if (rst) seen_mode <= 2'd0;
    else if (wr_en && addr < ADDR_W'(4)) seen_mode <= addr[1:0];
  end

  always_comb begin
    op2_wr    = wr_en && addr == ADDR_W'(4);
    res_touch = wr_en && (addr == ADDR_W'(4) || addr == ADDR_W'(5) || addr == ADDR_W'(6));
  end

  assert_ext_umul_R2: assert property (@(posedge clk) disable iff (rst)
    (op2_wr && seen_mode == 2'd0) |=> ext_q == '0);

  assert_zero_op_R2: assert property (@(posedge clk) disable iff (rst)
    (op2_wr && !byte_wr && wdata == '0 && !seen_mode[1]) |=> res_q == '0);

  assert_ext_smul_R3: assert property (@(posedge clk) disable iff (rst)
    (op2_wr && seen_mode == 2'd1) |=> ext_q == {DATA_W{res_q[PROD_W-1]}});

  assert_ext_umac_R4: assert property (@(posedge clk) disable iff (rst)
    (op2_wr && seen_mode == 2'd2) |=> ext_q[DATA_W-1:1] == '0);

  assert_ext_smac_R5: assert property (@(posedge clk) disable iff (rst)
    (op2_wr && seen_mode == 2'd3) |=> ext_q == {DATA_W{res_q[PROD_W-1]}});

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !res_touch |=> ($stable(res_q) && $stable(ext_q)));

endmodule

bind mac_periph mac_periph_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .byte_wr (byte_wr),
  .addr    (addr),
  .wdata   (wdata),
  .res_q   (res_q),
  .ext_q   (ext_q)
);

// File: tb/mac_periph_bench.sv
`timescale 1ns/1ps
module mac_periph_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NVEC   = 12;

  typedef struct packed {
    logic [1:0]  mode;
    logic        b1;
    logic [15:0] op1;
    logic        b2;
    logic [15:0] op2;
    logic [31:0] pre;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] ext;
  } vec_t;

  // mode: 0 umul, 1 smul, 2 umac, 3 smac (R1)
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 16'hFFFF, 1'b0, 16'hFFFF, 32'h1234_5678, 16'h0001, 16'hFFFE, 16'h0000}, // R2
    '{2'd1, 1'b0, 16'hFFFF, 1'b0, 16'h0002, 32'h1234_5678, 16'hFFFE, 16'hFFFF, 16'hFFFF}, // R3
    '{2'd1, 1'b0, 16'h7FFF, 1'b0, 16'h7FFF, 32'h0000_0000, 16'h0001, 16'h3FFF, 16'h0000}, // R3
    '{2'd2, 1'b0, 16'h0002, 1'b0, 16'h0001, 32'hFFFF_FFFF, 16'h0001, 16'h0000, 16'h0001}, // R4 carry
    '{2'd2, 1'b0, 16'h0003, 1'b0, 16'h0004, 32'h0000_0010, 16'h001C, 16'h0000, 16'h0000}, // R4
    '{2'd3, 1'b0, 16'hFFFD, 1'b0, 16'h0002, 32'h0000_0005, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R5
    '{2'd0, 1'b1, 16'hAB80, 1'b1, 16'hCDFF, 32'h0000_0000, 16'h7F80, 16'h0000, 16'h0000}, // R6 8x8 u
    '{2'd1, 1'b1, 16'hAB80, 1'b1, 16'h12FF, 32'h0000_0000, 16'h0080, 16'h0000, 16'h0000}, // R6 8x8 s
    '{2'd1, 1'b0, 16'h1000, 1'b1, 16'h00FE, 32'h0000_0000, 16'hE000, 16'hFFFF, 16'hFFFF}, // R6 16x8
    '{2'd0, 1'b1, 16'hFF10, 1'b0, 16'h1234, 32'h0000_0000, 16'h2340, 16'h0001, 16'h0000}, // R6 8x16
    '{2'd3, 1'b0, 16'h0001, 1'b0, 16'h0001, 32'h7FFF_FFFF, 16'h0000, 16'h8000, 16'hFFFF}, // R5 wrap
    '{2'd2, 1'b1, 16'h77FF, 1'b1, 16'h88FF, 32'h0000_0001, 16'hFE02, 16'h0000, 16'h0000}  // R4 bytes
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              byte_wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mac_periph #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mac_periph (
    .clk (clk), .rst (rst), .wr_en (wr_en), .byte_wr (byte_wr),
    .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d; byte_wr = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; byte_wr = 1'b0;
  endtask

  // sets the address at a falling edge; registered rdata is sampled after the next rise
  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = ADDR_W'(a);
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic preset(input logic [31:0] v);
    wr(5, v[15:0], 1'b0);
    wr(6, v[31:16], 1'b0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 check("R11 rdata in reset", rdata, 16'h0000);
    @(negedge clk) rst = 1'b0;

    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R11 register clear", v, 16'h0000);
    end

    for (int i = 0; i < NVEC; i++) begin
      preset(VEC[i].pre);
      wr(int'(VEC[i].mode), VEC[i].op1, VEC[i].b1);
      wr(4, VEC[i].op2, VEC[i].b2);
      rd(5, v); check("R1/R9 vector low word", v, VEC[i].lo);
      rd(6, v); check("R1 vector high word", v, VEC[i].hi);
      rd(7, v); check("R1 vector extension", v, VEC[i].ext);
    end

    // R7: operand readback after widening
    wr(1, 16'h3480, 1'b1);
    rd(1, v); check("R7 op1 signed byte readback", v, 16'hFF80);
    rd(0, v); check("R7 op1 alias readback", v, 16'hFF80);
    wr(4, 16'h00F0, 1'b1);
    rd(4, v); check("R6 op2 byte widened by held mode", v, 16'hFFF0);

    // R8: repeated operand-2 writes with held operand 1
    preset(32'h0);
    wr(2, 16'h0003, 1'b0);
    wr(4, 16'h0005, 1'b0);
    rd(5, v); check("R8 first accumulate", v, 16'h000F);
    wr(4, 16'h0005, 1'b0);
    rd(5, v); check("R8 repeat accumulate", v, 16'h001E);
    wr(4, 16'hAA02, 1'b1);
    rd(5, v); check("R8 repeat with byte op2", v, 16'h0024);

    // R10: multiply discards the preset
    preset(32'h0009_0009);
    wr(0, 16'h0007, 1'b0);
    wr(4, 16'h0006, 1'b0);
    rd(5, v); check("R10 multiply ignores preset lo", v, 16'h002A);
    rd(6, v); check("R10 multiply ignores preset hi", v, 16'h0000);

    // R9: result readable in the cycle straight after the trigger
    wr(4, 16'h0002, 1'b0);
    rd(5, v); check("R9 zero added latency", v, 16'h000E);

    // R11: reset mid-run
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    rd(0, v); check("R11 op1 after reset", v, 16'h0000);
    rd(6, v); check("R11 result after reset", v, 16'h0000);
    preset(32'h0000_0005);
    wr(4, 16'h0003, 1'b0);
    rd(5, v); check("R11 mode back to multiply", v, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule